// File: doc/BRIEF.md
# Boot Bank Remap Decoder

This block is the chip-select stage of an external memory controller that serves eight memory banks. Address decoding upstream names one bank per access. The block turns that request into a registered one-hot chip select. While the remap input is low, the boot bank (bank 7) also answers in the region of bank 0. Software can then fetch its first instructions from boot memory placed at the base address. Once the system raises remap, bank 0 holds its own device again and the boot bank answers only in its own region.

The block also keeps the data-width setting of every bank. A two-bit strap is captured while reset is held, and it gives the boot bank the right width before any software runs. The other banks start from fixed widths chosen by parameter. A write port lets software change the width of any bank later, including the boot bank.

Top module: `boot_bank_decoder`

## Requirements
- R1: When `remap` is 0, a valid request with `req_bank` = 0 asserts `bank_cs` bit 7 only, one cycle after the request is presented.
- R2: When `remap` is 0, `bank_cs` bit 0 is never asserted, whatever the request.
- R3: When `remap` is 1, a request for bank 0 asserts only `bank_cs` bit 0, and a request for bank 7 asserts only `bank_cs` bit 7.
- R4: A request for any of banks 1 to 6 asserts only the matching `bank_cs` bit, whatever the level of `remap`.
- R5: `bank_cs` is registered with one cycle of latency. It has at most one bit set, and it is all zero in the cycle after a cycle with `req_valid` low.
- R6: While `rst` is high, the bank 7 width field (`bank_width` bits 15:14) is loaded from `width_strap`. Strap 00 loads 0 (8-bit), 01 loads 1 (16-bit), 10 loads 2 (32-bit), and 11 loads the 8-bit default 0.
- R7: After reset, banks 0 to 6 hold their parameter widths. With the default parameter these are 2, 1, 0, 2, 1, 0, 2 for banks 0 to 6. Field k of `bank_width` sits at bits 2k+1:2k.
- R8: Changes on `width_strap` after `rst` falls have no effect on any width field.
- R9: A write with `wr_en` high loads `wr_width` into the field of bank `wr_bank`, bank 7 included, and the new value shows on `bank_width` one cycle later. A write of code 11 leaves the field unchanged, and no other field changes.
- R10: While `rst` is high, `bank_cs` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An access request is present this cycle |
| req_bank | input | 3 | Bank index from address decode |
| remap | input | 1 | Low: boot bank also answers in the bank 0 region |
| width_strap | input | 2 | Boot bank width code, sampled during reset |
| wr_en | input | 1 | Width field write strobe |
| wr_bank | input | 3 | Bank whose width field is written |
| wr_width | input | 2 | New width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = ignored) |
| bank_cs | output | 8 | Registered one-hot chip selects |
| bank_width | output | 16 | Width code of each bank, 2 bits per bank, bank 0 in the low bits |

## Verification
The properties assume that `rst` is high from time zero for at least one clock. They also assume that every bank index is below the bank count, which always holds with eight banks and a three-bit index. The width properties assume that width fields change only through the write port once reset has ended. The stimulus changes inputs only half a cycle away from the rising edge. It sweeps every index with both remap levels and both request levels, and it issues every write code to every bank. It also moves the strap only while reset is high or in a phase where it must have no effect.

// File: rtl/bootmap_pkg.sv
`timescale 1ns/1ps
package bootmap_pkg;
  localparam int unsigned WCODE_W = 2;

  typedef enum logic [WCODE_W-1:0] {
    BW_8    = 2'd0,
    BW_16   = 2'd1,
    BW_32   = 2'd2,
    BW_KEEP = 2'd3
  } bus_width_e;

  // Map a reset strap code to a width code; the "keep" code gives 8-bit.
  function automatic logic [WCODE_W-1:0] strap_to_width(input logic [WCODE_W-1:0] s);
    if (s == BW_KEEP) return BW_8;
    return s;
  endfunction
endpackage

// File: rtl/bank_select_decode.sv
`timescale 1ns/1ps
module bank_select_decode #(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned IDX_W       = 3,
  parameter int unsigned BOOT_BANK   = 7,
  parameter int unsigned SHADOW_BANK = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [IDX_W-1:0]     req_bank,
  input  logic                 remap,
  output logic [NUM_BANKS-1:0] cs
);
  localparam logic [IDX_W-1:0] BOOT_IDX   = IDX_W'(BOOT_BANK);
  localparam logic [IDX_W-1:0] SHADOW_IDX = IDX_W'(SHADOW_BANK);

  logic [IDX_W-1:0]     target;
  logic [NUM_BANKS-1:0] hit;

  // Shadow redirect: the bank 0 region goes to the boot bank while remap is low.
  always_comb begin
    if (!remap && req_bank == SHADOW_IDX) target = BOOT_IDX;
    else                                  target = req_bank;
  end

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_hit
    assign hit[k] = req_valid && (target == IDX_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) cs <= '0;
    else     cs <= hit;
  end
endmodule

// File: rtl/bank_width_regs.sv
`timescale 1ns/1ps
module bank_width_regs
  import bootmap_pkg::*;
#(
  parameter int unsigned               NUM_BANKS = 8,
  parameter int unsigned               IDX_W     = 3,
  parameter int unsigned               BOOT_BANK = 7,
  parameter logic [NUM_BANKS*2-1:0]    RESET_W   = 16'h2186
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WCODE_W-1:0]     width_strap,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_bank,
  input  logic [WCODE_W-1:0]     wr_width,
  output logic [NUM_BANKS*WCODE_W-1:0] widths
);
  logic wr_legal;
  assign wr_legal = wr_en && (wr_width != BW_KEEP);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_field
    logic [WCODE_W-1:0] rst_val;
    if (k == BOOT_BANK) begin : g_boot
      assign rst_val = strap_to_width(width_strap);
    end else begin : g_fixed
      assign rst_val = RESET_W[k*WCODE_W +: WCODE_W];
    end

    always_ff @(posedge clk) begin
      if (rst)
        widths[k*WCODE_W +: WCODE_W] <= rst_val;
      else if (wr_legal && wr_bank == IDX_W'(k))
        widths[k*WCODE_W +: WCODE_W] <= wr_width;
    end
  end
endmodule

// File: rtl/boot_bank_decoder.sv
`timescale 1ns/1ps
module boot_bank_decoder
  import bootmap_pkg::*;
#(
  parameter int unsigned            NUM_BANKS   = 8,
  parameter int unsigned            BOOT_BANK   = 7,
  parameter int unsigned            SHADOW_BANK = 0,
  parameter logic [NUM_BANKS*2-1:0] RESET_W     = 16'h2186,
  localparam int unsigned           IDX_W       = $clog2(NUM_BANKS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic [IDX_W-1:0]              req_bank,
  input  logic                          remap,
  input  logic [1:0]                    width_strap,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_bank,
  input  logic [1:0]                    wr_width,
  output logic [NUM_BANKS-1:0]          bank_cs,
  output logic [NUM_BANKS*WCODE_W-1:0]  bank_width
);
  bank_select_decode #(
    .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W),
    .BOOT_BANK(BOOT_BANK), .SHADOW_BANK(SHADOW_BANK)
  ) u_sel (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .remap(remap), .cs(bank_cs)
  );

  bank_width_regs #(
    .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W),
    .BOOT_BANK(BOOT_BANK), .RESET_W(RESET_W)
  ) u_wid (
    .clk(clk), .rst(rst), .width_strap(width_strap), .wr_en(wr_en),
    .wr_bank(wr_bank), .wr_width(wr_width), .widths(bank_width)
  );
endmodule

// File: rtl/boot_bank_decoder_chk.sv
`timescale 1ns/1ps
module boot_bank_decoder_chk #(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned IDX_W       = 3,
  parameter int unsigned BOOT_BANK   = 7,
  parameter int unsigned SHADOW_BANK = 0
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic [IDX_W-1:0]       req_bank,
  input logic                   remap,
  input logic                   wr_en,
  input logic [NUM_BANKS-1:0]   bank_cs,
  input logic [NUM_BANKS*2-1:0] bank_width
);
  localparam logic [NUM_BANKS-1:0] BOOT_HOT = NUM_BANKS'(1) << BOOT_BANK;

  // R1
  shadow_to_boot_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !remap && req_bank == IDX_W'(SHADOW_BANK)) |=> bank_cs == BOOT_HOT);

  // R2
  shadow_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    !remap |=> !bank_cs[SHADOW_BANK]);

  // R3
  own_region_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && remap) |=> bank_cs == (NUM_BANKS'(1) << $past(req_bank)));

  // R4
  plain_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_bank != IDX_W'(SHADOW_BANK)) |=> bank_cs == (NUM_BANKS'(1) << $past(req_bank)));

  // R5
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(bank_cs));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> bank_cs == '0);

  // R8
  width_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bank_width));

  // R10
  always_ff @(posedge clk) begin
    if (rst) begin
      reset_quiet_chk: assert (bank_cs == '0 || $past(!rst));
    end
  end

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_legal
    // R9
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
      bank_width[k*2 +: 2] != 2'b11);
  end
endmodule

bind boot_bank_decoder boot_bank_decoder_chk #(
  .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W),
  .BOOT_BANK(BOOT_BANK), .SHADOW_BANK(SHADOW_BANK)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
  .remap(remap), .wr_en(wr_en), .bank_cs(bank_cs), .bank_width(bank_width)
);

// File: tb/boot_bank_decoder_test.sv
`timescale 1ns/1ps
module boot_bank_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_bank = '0;
  logic        remap = 1'b0;
  logic [1:0]  width_strap = 2'b11;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_bank = '0;
  logic [1:0]  wr_width = '0;
  logic [7:0]  bank_cs;
  logic [15:0] bank_width;

  int checks = 0;
  int errors = 0;
  logic [1:0] model [8];

  always #5 clk = ~clk;

  boot_bank_decoder uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .remap(remap), .width_strap(width_strap), .wr_en(wr_en),
    .wr_bank(wr_bank), .wr_width(wr_width),
    .bank_cs(bank_cs), .bank_width(bank_width)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_cs(input string req, input logic [7:0] exp);
    checks++;
    if (bank_cs !== exp) begin
      errors++;
      $display("FAIL %s bank_cs actual %b expected %b", req, bank_cs, exp);
    end
  endtask

  task automatic check_widths(input string req);
    logic [15:0] exp;
    for (int k = 0; k < 8; k++) exp[k*2 +: 2] = model[k];
    checks++;
    if (bank_width !== exp) begin
      errors++;
      $display("FAIL %s bank_width actual %h expected %h", req, bank_width, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] strap);
    rst = 1'b1;
    width_strap = strap;
    step();
    step();
    check_cs("R10", 8'h00);
    rst = 1'b0;
    step();
    for (int k = 0; k < 7; k++) model[k] = 2'(2 - (k % 3)); // R7
    model[7] = (strap == 2'b11) ? 2'd0 : strap;               // R6
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R6 R7 R8: every strap code, then strap moved after reset
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      check_widths("R6_R7");
      width_strap = ~2'(s);
      step();
      step();
      check_widths("R8");
    end

    // Decode sweep: R1 R2 R3 R4 R5
    for (int r = 0; r < 2; r++) begin
      for (int v = 0; v < 2; v++) begin
        for (int i = 0; i < 8; i++) begin
          logic [7:0] exp;
          string tag;
          remap = r[0];
          req_valid = v[0];
          req_bank = 3'(i);
          if (!v[0]) begin
            exp = 8'h00; tag = "R5";
          end else if (i == 0 && r == 0) begin
            exp = 8'h80; tag = "R1_R2";
          end else begin
            exp = 8'(1) << i;
            tag = (i == 0 || i == 7) ? "R3" : "R4";
          end
          step();
          check_cs(tag, exp);
        end
      end
    end
    req_valid = 1'b0;
    step();
    check_cs("R5", 8'h00);

    // R9: every code to every bank, code 3 ignored
    for (int b = 0; b < 8; b++) begin
      for (int c = 0; c < 4; c++) begin
        wr_en = 1'b1;
        wr_bank = 3'(b);
        wr_width = 2'(c);
        step();
        wr_en = 1'b0;
        if (c != 3) model[b] = 2'(c);
        check_widths("R9");
      end
    end

    // R10: reset mid-request clears the selects
    req_valid = 1'b1;
    req_bank = 3'd3;
    step();
    check_cs("R4", 8'h08);
    rst = 1'b1;
    step();
    check_cs("R10", 8'h00);
    rst = 1'b0;
    req_valid = 1'b0;
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule